// File: doc/BRIEF.md
# Timer Counter with Edge Capture

This block is an 8-bit timer/counter with a selectable count clock and an input-capture mode. The count clock is the system clock divided by 4, 16 or 64, or the rising edges of an external clock pin. In normal mode the counter runs up to a compare value held in a data register. When it reaches that value, the next count tick returns it to zero and raises a one-cycle timer interrupt pulse.

In capture mode the counter keeps stepping the same way, but it wraps freely and never raises the timer interrupt. A qualifying transition on the capture pin copies the running count into a capture register and clears the counter in the same clock, and counting carries on without software. The kind of transition that qualifies is programmable. Every qualifying transition pulses the capture interrupt output, in either mode.

Software reaches the block through a simple register bus with three locations: the mode register, a shared data/capture location, and the live count. Reads from the shared location follow the mode, and writes to it always go to the data register. Both pins pass through synchronisers before use.

Top module: `timer_capture`

## Requirements
- R1: While rst_n is low, every register clears. After reset, address 0, address 1 and address 2 all read 00h, and both interrupt outputs are low.
- R2: Mode bits [2:1] select the count tick. 00 selects the system clock divided by 4, 01 divided by 16, and 10 divided by 64, all taken from one free-running prescaler that clears at reset. 11 selects the rising edges of ext_clk_pin after a two-flop synchroniser.
- R3: Mode bit 0 is the run bit. A mode write with bit 0 = 1 clears the counter and starts it. A mode write with bit 0 = 0 stops the counter, and the count then holds.
- R4: In normal mode (mode bit 3 = 0) a running counter steps by one on each tick. A tick that finds the count equal to the data register clears the count to 0 and pulses tmr_irq high for exactly one cycle.
- R5: In capture mode (mode bit 3 = 1) the counter steps on each tick and wraps from FFh to 00h. tmr_irq stays low.
- R6: In capture mode a qualifying capture edge loads the current count into the capture register and clears the counter. A running counter keeps counting afterwards.
- R7: Mode bits [5:4] select the qualifying edge on cap_pin, which passes through a two-flop synchroniser: 00 = none, 01 = falling, 10 = rising, 11 = both.
- R8: Every qualifying edge pulses cap_irq for one cycle in either mode. In normal mode an edge leaves the counter and the capture register untouched.
- R9: In capture mode a read at address 1 returns the capture register, and in normal mode it returns the data register. A write at address 1 always updates the data register.
- R10: Address 0 reads the mode register with bits 7:6 as zero. Address 2 reads the live count. Address 3 reads 00h.
- R11: When a mode write and a capture edge land in the same cycle, the mode write decides the counter, and the capture register is still loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously to clk |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | 2 | Register address (0 mode, 1 data/capture, 2 count, 3 none) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| ext_clk_pin | input | 1 | External count clock, asynchronous |
| cap_pin | input | 1 | Capture trigger pin, asynchronous |
| tmr_irq | output | 1 | One-cycle compare-match interrupt pulse |
| cap_irq | output | 1 | One-cycle pulse per qualifying capture edge |

## Verification
The assertions assume that rst_n is released synchronously to clk and that at most one register write arrives per cycle. They also assume that the pins change slowly enough that the synchronised level holds for at least one cycle, so that each edge is seen exactly once. The bench meets these assumptions by changing every input just after a clock edge and by toggling the pins no faster than once every few cycles. The bench also places mode writes at several cycle offsets from a pin toggle, so that the same-cycle collision between a write and a capture edge is exercised on purpose.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    CLK_DIV_A = 2'b00,
    CLK_DIV_B = 2'b01,
    CLK_DIV_C = 2'b10,
    CLK_EXT   = 2'b11
  } clk_sel_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ADDR_MODE  = 2'b00,
    ADDR_DATA  = 2'b01,
    ADDR_COUNT = 2'b10,
    ADDR_NONE  = 2'b11
  } reg_addr_e;

  // mode register layout: [5:4] edge select, [3] capture enable,
  // [2:1] clock select, [0] run
  typedef struct packed {
    edge_sel_e edge_sel;
    logic      cap_en;
    clk_sel_e  clk_sel;
    logic      run;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);
endpackage

// File: rtl/tc_sync.sv
module tc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tc_tick_gen.sv
module tc_tick_gen
  import tc_pkg::*;
#(
  parameter int unsigned DIV_A_LOG2  = 2,
  parameter int unsigned DIV_B_LOG2  = 4,
  parameter int unsigned DIV_C_LOG2  = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_sel_e sel,
  input  logic     ext_pin,
  output logic     tick
);
  localparam int unsigned PRE_W    = DIV_C_LOG2;
  localparam int unsigned N_TAPS   = 3;
  localparam int unsigned TAP_LOG2 [N_TAPS] = '{DIV_A_LOG2, DIV_B_LOG2, DIV_C_LOG2};

  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  pre_d;
  logic [N_TAPS-1:0] div_tick;
  logic              ext_s;
  logic              ext_prev_q;
  logic              ext_prev_d;
  logic              ext_tick;

  // one terminal-count detector per division tap
  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    assign div_tick[g] = &pre_q[TAP_LOG2[g]-1:0];
  end

  tc_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ext_pin),
    .q    (ext_s)
  );

  always_comb begin
    pre_d      = pre_q + 1'b1;
    ext_prev_d = ext_s;
    ext_tick   = ext_s & ~ext_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q      <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      pre_q      <= pre_d;
      ext_prev_q <= ext_prev_d;
    end
  end

  always_comb begin
    unique case (sel)
      CLK_DIV_A: tick = div_tick[0];
      CLK_DIV_B: tick = div_tick[1];
      CLK_DIV_C: tick = div_tick[2];
      default:   tick = ext_tick;
    endcase
  end
endmodule

// File: rtl/tc_edge_det.sv
module tc_edge_det
  import tc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  input  edge_sel_e sel,
  output logic      hit
);
  logic pin_s;
  logic prev_q;
  logic prev_d;
  logic rise;
  logic fall;

  tc_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin),
    .q    (pin_s)
  );

  always_comb begin
    prev_d = pin_s;
    rise   = pin_s & ~prev_q;
    fall   = ~pin_s & prev_q;
    unique case (sel)
      EDGE_FALL: hit = fall;
      EDGE_RISE: hit = rise;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             cap_en,
  input  logic             hit,
  input  logic             start_wr,
  input  logic             start_val,
  input  logic [WIDTH-1:0] limit,
  output logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] cap,
  output logic             match_irq
);
  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] cap_q, cap_d;
  logic             irq_q, irq_d;
  logic             cap_evt;
  logic             at_limit;

  always_comb begin
    cap_evt  = cap_en & hit;
    at_limit = (cnt_q == limit);
    cnt_d    = cnt_q;
    cap_d    = cap_q;
    irq_d    = 1'b0;

    if (cap_evt) cap_d = cnt_q;

    if (start_wr) begin
      if (start_val) cnt_d = '0;
    end else if (cap_evt) begin
      cnt_d = '0;
    end else if (run && tick) begin
      if (!cap_en && at_limit) begin
        cnt_d = '0;
        irq_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
      irq_q <= irq_d;
    end
  end

  assign cnt       = cnt_q;
  assign cap       = cap_q;
  assign match_irq = irq_q;
endmodule

// File: rtl/timer_capture.sv
module timer_capture
  import tc_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_A_LOG2  = 2,
  parameter int unsigned DIV_B_LOG2  = 4,
  parameter int unsigned DIV_C_LOG2  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             ext_clk_pin,
  input  logic             cap_pin,
  output logic             tmr_irq,
  output logic             cap_irq
);
  localparam int unsigned PAD_W = WIDTH - MODE_W;

  mode_t            mode_q, mode_d;
  logic [WIDTH-1:0] data_q, data_d;
  logic             cap_irq_q, cap_irq_d;
  logic             mode_wr;
  logic             data_wr;
  logic             tick;
  logic             hit;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] cap;
  reg_addr_e        addr;

  assign addr = reg_addr_e'(bus_addr);

  always_comb begin
    mode_wr   = bus_wr && (addr == ADDR_MODE);
    data_wr   = bus_wr && (addr == ADDR_DATA);
    mode_d    = mode_wr ? mode_t'(bus_wdata[MODE_W-1:0]) : mode_q;
    data_d    = data_wr ? bus_wdata : data_q;
    cap_irq_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      data_q    <= '0;
      cap_irq_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      data_q    <= data_d;
      cap_irq_q <= cap_irq_d;
    end
  end

  tc_tick_gen #(
    .DIV_A_LOG2 (DIV_A_LOG2),
    .DIV_B_LOG2 (DIV_B_LOG2),
    .DIV_C_LOG2 (DIV_C_LOG2),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (mode_q.clk_sel),
    .ext_pin(ext_clk_pin),
    .tick   (tick)
  );

  tc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (cap_pin),
    .sel  (mode_q.edge_sel),
    .hit  (hit)
  );

  tc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (mode_q.run),
    .cap_en   (mode_q.cap_en),
    .hit      (hit),
    .start_wr (mode_wr),
    .start_val(bus_wdata[0]),
    .limit    (data_q),
    .cnt      (cnt),
    .cap      (cap),
    .match_irq(tmr_irq)
  );

  always_comb begin
    unique case (addr)
      ADDR_MODE:  bus_rdata = {{PAD_W{1'b0}}, mode_q};
      ADDR_DATA:  bus_rdata = mode_q.cap_en ? cap : data_q;
      ADDR_COUNT: bus_rdata = cnt;
      default:    bus_rdata = '0;
    endcase
  end

  assign cap_irq = cap_irq_q;
endmodule

// File: rtl/timer_capture_checker.sv
module timer_capture_checker
  import tc_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input mode_t            mode_q,
  input logic             tick,
  input logic             hit,
  input logic [WIDTH-1:0] cnt,
  input logic             tmr_irq,
  input logic             cap_irq
);
  logic mode_wr;
  logic cap_evt;
  assign mode_wr = bus_wr && (bus_addr == ADDR_MODE);
  assign cap_evt = mode_q.cap_en && hit;

  // R5: no compare interrupt while capture mode is selected
  a_r5_no_tmr_irq_in_capture: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.cap_en |=> !tmr_irq);

  // R7: edge select off means no capture flag
  a_r7_edge_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.edge_sel == EDGE_OFF) |=> !cap_irq);

  // R6: a capture edge clears the count unless a mode write takes the cycle
  a_r6_capture_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !mode_wr) |=> (cnt == '0));

  // R3: a stopped counter holds its value
  a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q.run && !mode_wr && !cap_evt) |=> $stable(cnt));

  // R4: a running counter moves only on a tick
  a_r4_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.run && !tick && !mode_wr && !cap_evt) |=> $stable(cnt));

  // R4: a tick either steps the count by one or returns it to zero
  a_r4_tick_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.run && tick && !mode_wr && !cap_evt) |=>
      ((cnt == WIDTH'($past(cnt) + 1'b1)) || (cnt == '0)));
endmodule

bind timer_capture timer_capture_checker #(.WIDTH(WIDTH)) u_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr),
  .mode_q  (mode_q),
  .tick    (tick),
  .hit     (hit),
  .cnt     (cnt),
  .tmr_irq (tmr_irq),
  .cap_irq (cap_irq)
);

// File: tb/timer_capture_test.sv
`timescale 1ns/1ps
module timer_capture_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_clk_pin = 1'b0;
  logic       cap_pin = 1'b0;
  logic       tmr_irq;
  logic       cap_irq;

  int total = 0;
  int bad = 0;
  int tirq_seen = 0;
  int cirq_seen = 0;
  int rot = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  timer_capture uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_pin(ext_clk_pin),
    .cap_pin(cap_pin), .tmr_irq(tmr_irq), .cap_irq(cap_irq)
  );

  // behavioural reference model
  logic [7:0] m_mode, m_data, m_cap, m_cnt;
  logic       m_tirq, m_cirq;
  int         m_pre;
  bit         e1, e2, e3, c1, c2, c3;
  bit         m_tick, m_hit, m_mwr, m_rise, m_fall;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_data = 0; m_cap = 0; m_cnt = 0; m_tirq = 0; m_cirq = 0;
      m_pre = 0; e1 = 0; e2 = 0; e3 = 0; c1 = 0; c2 = 0; c3 = 0;
    end else begin
      case (m_mode[2:1])
        2'd0: m_tick = (m_pre % 4) == 3;
        2'd1: m_tick = (m_pre % 16) == 15;
        2'd2: m_tick = (m_pre % 64) == 63;
        default: m_tick = e2 && !e3;
      endcase
      m_rise = c2 && !c3;
      m_fall = !c2 && c3;
      case (m_mode[5:4])
        2'd1: m_hit = m_fall;
        2'd2: m_hit = m_rise;
        2'd3: m_hit = m_rise || m_fall;
        default: m_hit = 0;
      endcase
      m_mwr  = bus_wr && bus_addr == 2'd0;
      m_cirq = m_hit;
      m_tirq = !m_mwr && m_mode[0] && m_tick && !m_mode[3] && m_cnt == m_data;
      if (m_mode[3] && m_hit) m_cap = m_cnt;
      if (m_mwr) begin
        if (bus_wdata[0]) m_cnt = 0;
      end else if (m_mode[3] && m_hit) m_cnt = 0;
      else if (m_mode[0] && m_tick) m_cnt = m_tirq ? 8'd0 : m_cnt + 8'd1;
      if (m_mwr) m_mode = bus_wdata & 8'h3F;
      if (bus_wr && bus_addr == 2'd1) m_data = bus_wdata;
      m_pre = (m_pre + 1) % 64;
      e3 = e2; e2 = e1; e1 = ext_clk_pin;
      c3 = c2; c2 = c1; c1 = cap_pin;
    end
  end

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_mode;
      2'd1: return m_mode[3] ? m_cap : m_data;
      2'd2: return m_cnt;
      default: return 8'd0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (tmr_irq) tirq_seen++;
    if (cap_irq) cirq_seen++;
    check(cur_tag, int'(bus_rdata), int'(m_read(bus_addr)), $sformatf("rdata addr%0d", bus_addr));
    check(cur_tag, int'(tmr_irq), int'(m_tirq), "tmr_irq");
    check(cur_tag, int'(cap_irq), int'(m_cirq), "cap_irq");
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n, input int cap_per, input int ext_per);
    for (int i = 0; i < n; i++) begin
      bus_addr = 2'(rot % 4);
      rot++;
      if (cap_per > 0 && (i % cap_per) == cap_per - 1) cap_pin = ~cap_pin;
      if (ext_per > 0 && (i % ext_per) == ext_per - 1) ext_clk_pin = ~ext_clk_pin;
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0, c0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values
    cur_tag = "R1";
    for (int a = 0; a < 3; a++) begin
      bus_addr = 2'(a);
      #1 check("R1", int'(bus_rdata), 0, $sformatf("reset read addr%0d", a));
    end
    check("R1", int'(tmr_irq), 0, "reset tmr_irq");
    check("R1", int'(cap_irq), 0, "reset cap_irq");
    idle(4, 0, 0);

    // R4 normal compare match, divide by 4
    cur_tag = "R4";
    wr(2'd1, 8'd5);
    wr(2'd0, 8'h01);
    t0 = tirq_seen;
    idle(150, 0, 0);
    check("R4", int'(tirq_seen > t0 + 4), 1, "compare interrupts seen");

    // R2 clock selections
    cur_tag = "R2";
    wr(2'd1, 8'd200);
    wr(2'd0, 8'h03); idle(200, 0, 0);
    wr(2'd0, 8'h05); idle(300, 0, 0);
    wr(2'd0, 8'h07); idle(200, 0, 5);
    bus_addr = 2'd2; #1;
    check("R2", int'(bus_rdata != 0), 1, "external clock advanced count");

    // R3 stop and restart
    cur_tag = "R3";
    wr(2'd0, 8'h00); idle(40, 0, 0);
    wr(2'd0, 8'h01); idle(20, 0, 0);

    // R5 capture mode free wrap, no compare interrupt
    cur_tag = "R5";
    wr(2'd1, 8'd3);
    t0 = tirq_seen;
    wr(2'd0, 8'h09); idle(1100, 0, 0);
    check("R5", tirq_seen - t0, 0, "tmr_irq in capture mode");

    // R6 / R7 capture on each edge kind
    cur_tag = "R6";
    wr(2'd0, 8'h29); idle(400, 37, 0);
    cur_tag = "R7";
    wr(2'd0, 8'h19); idle(300, 41, 0);
    wr(2'd0, 8'h39); idle(300, 29, 0);
    c0 = cirq_seen;
    wr(2'd0, 8'h09); idle(200, 23, 0);
    check("R7", cirq_seen - c0, 0, "cap_irq with edge select off");

    // R8 edge flags in normal mode
    cur_tag = "R8";
    wr(2'd1, 8'd250);
    c0 = cirq_seen;
    wr(2'd0, 8'h21); idle(300, 31, 0);
    check("R8", int'(cirq_seen > c0), 1, "cap_irq in normal mode");

    // R9 shared address routing
    cur_tag = "R9";
    wr(2'd0, 8'h29); idle(60, 17, 0);
    wr(2'd1, 8'h77); idle(20, 0, 0);
    wr(2'd0, 8'h01);
    bus_addr = 2'd1; #1;
    check("R9", int'(bus_rdata), 8'h77, "data register after capture-mode write");
    idle(10, 0, 0);

    // R11 mode write colliding with a capture edge
    cur_tag = "R11";
    wr(2'd0, 8'h39); idle(30, 0, 0);
    for (int off = 0; off < 6; off++) begin
      cap_pin = ~cap_pin;
      idle(off, 0, 0);
      wr(2'd0, (off % 2) ? 8'h39 : 8'h38);
      idle(10, 0, 0);
    end

    // R10 mode read mask and unused address
    cur_tag = "R10";
    wr(2'd0, 8'hFF);
    bus_addr = 2'd0; #1;
    check("R10", int'(bus_rdata), 8'h3F, "mode read mask");
    bus_addr = 2'd3; #1;
    check("R10", int'(bus_rdata), 0, "address 3 read");
    idle(40, 7, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule